// File: doc/BRIEF.md
# Card Access Phase Timer

This block times a single access to a removable card. Each access is split into three back-to-back intervals. First comes an address-setup interval, then the interval in which the command strobe is driven, and last a recovery interval. Once recovery ends, the block reports that the access is complete. Every interval is a whole number of clock periods, and the clock period is the unit of all timing.

Each interval is programmed through its own 8-bit timing register. Within a register, a two-bit field selects a coarse prescaler and a six-bit field holds a multiplier. A small register port reads and writes the three registers, and all three come out of reset with working values. The sequencer takes a copy of all three lengths when it accepts a request. Register traffic during an access therefore changes only later accesses.

Top module: `card_cycle_timer`

## Requirements
- R1: After reset, `cyc_busy`, `addr_phase`, `cmd_strobe`, `rec_phase` and `cyc_done` are low. The setup, command and recovery registers read 01h, 06h and 03h.
- R2: The registers are mapped at indices 3Ah (setup), 3Bh (command) and 3Ch (recovery). A write with `reg_we` high updates the register addressed by `reg_addr`. `reg_rdata` shows the addressed register combinationally. Any other index reads 00h, and a write to it changes no register.
- R3: An interval lasts (M << (4*P)) + 1 clocks. M is register bits [5:0]. P is register bits [7:6], which selects a prescaler of 1, 16, 256 or 4096.
- R4: A request seen high while idle starts the setup interval in the next cycle. Command follows setup, and recovery follows command, with no gap between them.
- R5: `addr_phase` is high only in setup, `cmd_strobe` only in command and `rec_phase` only in recovery. At most one of the three is high at any time.
- R6: `cyc_done` is high for exactly one cycle, the cycle right after the last recovery cycle, and `cyc_busy` is low in that cycle.
- R7: `cyc_busy` is high from the first setup cycle to the last recovery cycle. A request raised while busy is dropped and does not start a later access.
- R8: A register write made during an access leaves that access's interval lengths unchanged. The new value applies from the next access.
- R9: With the reset values, an access takes 2 setup, 7 command and 4 recovery clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its period is the timing unit |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_req | input | 1 | Request to start an access |
| cyc_busy | output | 1 | Access in progress |
| addr_phase | output | 1 | Address-setup interval active |
| cmd_strobe | output | 1 | Command strobe |
| rec_phase | output | 1 | Recovery interval active |
| cyc_done | output | 1 | One-cycle completion pulse |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of addressed register |

## Verification
The bench sets a multiplier of zero, which gives one-clock intervals. A design that leaves out the extra clock or decrements past zero would produce zero-length or wrapped intervals. It also tries prescaler codes 2 and 3. A design that misdecodes the prescaler shift would produce intervals of the wrong length by factors of sixteen. Registers are rewritten in the middle of an access, which exposes a design that reads live registers instead of a snapshot. A request is pulsed while busy, which catches a design that queues it and restarts right after the done pulse. Unmapped indices are written and read back to catch decoders that alias onto a timing register.

// File: rtl/cct_pkg.sv
// Shared types for the card access phase timer.
// Assumes: three timing registers in a fixed order setup, command, recovery.
package cct_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_CMD   = 2'd2,
        PH_REC   = 2'd3
    } phase_e;

    localparam int unsigned N_TREG  = 3;
    localparam int unsigned T_SETUP = 0;
    localparam int unsigned T_CMD   = 1;
    localparam int unsigned T_REC   = 2;
endpackage

// File: rtl/cct_regs.sv
// Timing register file: three byte registers at consecutive indices from
// BASE_IDX, with reset defaults and a combinational read port.
// Assumes: single write port, writes take one clock, unmapped reads return 0.
module cct_regs
    import cct_pkg::*;
#(
    parameter int unsigned     DATA_W    = 8,
    parameter int unsigned     ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_IDX = 8'h3A,
    parameter logic [DATA_W-1:0] SETUP_DEF = 8'h01,
    parameter logic [DATA_W-1:0] CMD_DEF   = 8'h06,
    parameter logic [DATA_W-1:0] REC_DEF   = 8'h03
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [DATA_W-1:0]             wdata_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic [N_TREG-1:0][DATA_W-1:0] treg_o
);
    localparam logic [N_TREG-1:0][DATA_W-1:0] DEFS = {REC_DEF, CMD_DEF, SETUP_DEF};

    logic [N_TREG-1:0] hit;

    for (genvar g = 0; g < N_TREG; g++) begin : g_treg
        // Address decode for register g.
        assign hit[g] = (addr_i == ADDR_W'(BASE_IDX + ADDR_W'(g)));

        // Hold register g, loading its default on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                treg_o[g] <= DEFS[g];
            else if (we_i && hit[g])
                treg_o[g] <= wdata_i;
        end
    end

    // Return the addressed register, or zero when nothing matches.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_TREG; i++)
            if (hit[i]) rdata_o = treg_o[i];
    end
endmodule

// File: rtl/cct_len_calc.sv
// Converts one timing register into an interval length in clocks:
// (multiplier << (PRE_STEP * prescaler code)) + 1.
// Assumes: DATA_W = MULT_W + PSEL_W and CNT_W holds the largest length.
module cct_len_calc #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned MULT_W   = 6,
    parameter int unsigned PSEL_W   = 2,
    parameter int unsigned PRE_STEP = 4,
    parameter int unsigned CNT_W    = 19
) (
    input  logic [DATA_W-1:0] treg_i,
    output logic [CNT_W-1:0]  len_o
);
    logic [CNT_W-1:0] mult_ext;
    logic [31:0]      shamt;

    // Split the register into its multiplier and prescaler shift.
    always_comb begin
        mult_ext = CNT_W'(treg_i[MULT_W-1:0]);
        shamt    = 32'(treg_i[MULT_W +: PSEL_W]) * PRE_STEP;
        len_o    = (mult_ext << shamt) + CNT_W'(1);
    end
endmodule

// File: rtl/cct_seq.sv
// Phase sequencer: on a request while idle, snapshots the three interval
// lengths and steps setup -> command -> recovery, then pulses done.
// Assumes: every length is at least 1; requests during an access are dropped.
module cct_seq
    import cct_pkg::*;
#(
    parameter int unsigned CNT_W = 19
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_i,
    input  logic [N_TREG-1:0][CNT_W-1:0] len_i,
    output phase_e                       phase_o,
    output logic                         done_o
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmd_len_q;
    logic [CNT_W-1:0] rec_len_q;
    logic             last;

    assign last    = (cnt_q == '0);
    assign phase_o = phase_q;

    // Advance the phase machine and its down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            cmd_len_q <= '0;
            rec_len_q <= '0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            unique case (phase_q)
                PH_IDLE: if (req_i) begin
                    phase_q   <= PH_SETUP;
                    cnt_q     <= len_i[T_SETUP] - CNT_W'(1);
                    cmd_len_q <= len_i[T_CMD];
                    rec_len_q <= len_i[T_REC];
                end
                PH_SETUP: if (last) begin
                    phase_q <= PH_CMD;
                    cnt_q   <= cmd_len_q - CNT_W'(1);
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_CMD: if (last) begin
                    phase_q <= PH_REC;
                    cnt_q   <= rec_len_q - CNT_W'(1);
                end else cnt_q <= cnt_q - CNT_W'(1);
                PH_REC: if (last) begin
                    phase_q <= PH_IDLE;
                    done_o  <= 1'b1;
                end else cnt_q <= cnt_q - CNT_W'(1);
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/card_cycle_timer.sv
// Top level of the card access phase timer: register file, one length
// calculator per timing register, and the phase sequencer.
// Assumes: one clock domain; the clock period is the timing unit.
module card_cycle_timer
    import cct_pkg::*;
#(
    parameter int unsigned MULT_W   = 6,
    parameter int unsigned PSEL_W   = 2,
    parameter int unsigned PRE_STEP = 4,
    parameter int unsigned ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] BASE_IDX = 8'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_req,
    output logic              cyc_busy,
    output logic              addr_phase,
    output logic              cmd_strobe,
    output logic              rec_phase,
    output logic              cyc_done,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [MULT_W+PSEL_W-1:0] reg_wdata,
    output logic [MULT_W+PSEL_W-1:0] reg_rdata
);
    localparam int unsigned DATA_W = MULT_W + PSEL_W;
    localparam int unsigned CNT_W  = MULT_W + PRE_STEP * ((1 << PSEL_W) - 1) + 1;

    logic [N_TREG-1:0][DATA_W-1:0] treg;
    logic [N_TREG-1:0][CNT_W-1:0]  len;
    phase_e                        phase;

    cct_regs #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BASE_IDX (BASE_IDX)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .treg_o  (treg)
    );

    for (genvar g = 0; g < N_TREG; g++) begin : g_len
        cct_len_calc #(
            .DATA_W   (DATA_W),
            .MULT_W   (MULT_W),
            .PSEL_W   (PSEL_W),
            .PRE_STEP (PRE_STEP),
            .CNT_W    (CNT_W)
        ) u_len (
            .treg_i (treg[g]),
            .len_o  (len[g])
        );
    end

    cct_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (cyc_req),
        .len_i   (len),
        .phase_o (phase),
        .done_o  (cyc_done)
    );

    // Decode the phase into the external strobes.
    always_comb begin
        addr_phase = (phase == PH_SETUP);
        cmd_strobe = (phase == PH_CMD);
        rec_phase  = (phase == PH_REC);
        cyc_busy   = (phase != PH_IDLE);
    end
endmodule

// File: rtl/cct_checker.sv
// Protocol checks on the external behaviour of card_cycle_timer.
module cct_checker (
    input logic clk,
    input logic rst_n,
    input logic cyc_req,
    input logic cyc_busy,
    input logic addr_phase,
    input logic cmd_strobe,
    input logic rec_phase,
    input logic cyc_done
);
    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_phase, cmd_strobe, rec_phase}));

    p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_busy && cyc_req) |=> addr_phase);

    p_cmd_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_strobe) |-> $past(addr_phase));

    p_rec_after_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_phase) |-> $past(cmd_strobe));

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |-> !cyc_busy);

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done);

    p_done_follows_rec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rec_phase) |-> cyc_done);

    p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_busy && !rec_phase) |=> cyc_busy);
endmodule

bind card_cycle_timer cct_checker u_cct_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_req    (cyc_req),
    .cyc_busy   (cyc_busy),
    .addr_phase (addr_phase),
    .cmd_strobe (cmd_strobe),
    .rec_phase  (rec_phase),
    .cyc_done   (cyc_done)
);

// File: tb/test_card_cycle_timer.sv
module test_card_cycle_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_req = 1'b0;
    logic       cyc_busy, addr_phase, cmd_strobe, rec_phase, cyc_done;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] sh [3];

    always #2 clk = ~clk;

    card_cycle_timer i_card_cycle_timer (
        .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .cyc_busy(cyc_busy),
        .addr_phase(addr_phase), .cmd_strobe(cmd_strobe), .rec_phase(rec_phase),
        .cyc_done(cyc_done), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic int exp_len(input logic [7:0] r);
        return (int'(r[5:0]) << (4 * int'(r[7:6]))) + 1;
    endfunction

    function automatic logic [7:0] gen_reg();
        logic [1:0] p;
        p = ($urandom % 4 == 0) ? 2'd1 : 2'd0;
        return {p, 6'($urandom % 64)};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual %0d expected %0d", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 8'h3A && a <= 8'h3C) sh[a - 8'h3A] = d;
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [7:0] expv, input string rq);
        reg_addr = a;
        #1;
        chk(reg_rdata === expv, rq, $sformatf("read idx %0h", a), int'(reg_rdata), int'(expv));
    endtask

    // Run one access and measure it at the ports; optionally poke a register
    // write and a request while the access is running (R7, R8).
    task automatic do_cycle(input bit poke);
        int es, ec, er, ns, nc, nr, lim, pidx;
        bit bad, excl, seen, poked;
        logic [7:0] pval;
        es = exp_len(sh[0]); ec = exp_len(sh[1]); er = exp_len(sh[2]);
        ns = 0; nc = 0; nr = 0; bad = 0; excl = 0; seen = 0; poked = 0;
        pidx = 0; pval = 8'h00;
        lim = es + ec + er + 8;
        cyc_req = 1'b1;
        @(negedge clk);
        cyc_req = 1'b0;
        for (int k = 0; k < lim; k++) begin
            reg_we = 1'b0;
            cyc_req = 1'b0;
            if (int'(addr_phase) + int'(cmd_strobe) + int'(rec_phase) > 1) excl = 1;
            if (cyc_busy !== (addr_phase | cmd_strobe | rec_phase)) bad = 1;
            if (cyc_done) begin
                seen = 1;
                chk(cyc_busy === 1'b0, "R6", "busy during done", int'(cyc_busy), 0);
                break;
            end
            if (addr_phase) begin
                if (nc != 0 || nr != 0) bad = 1;
                ns++;
            end else if (cmd_strobe) begin
                if (nr != 0) bad = 1;
                nc++;
            end else if (rec_phase) begin
                nr++;
            end else bad = 1;
            if (poke && !poked && ns == 1) begin
                poked = 1;
                pidx = int'($urandom % 3);
                pval = gen_reg();
                reg_we = 1'b1; reg_addr = 8'h3A + 8'(pidx); reg_wdata = pval;
                cyc_req = 1'b1;
            end
            @(negedge clk);
        end
        reg_we = 1'b0;
        cyc_req = 1'b0;
        chk(ns == es, "R3", "setup clocks", ns, es);
        chk(nc == ec, "R3", "command clocks", nc, ec);
        chk(nr == er, "R3", "recovery clocks", nr, er);
        chk(!bad, "R4", "phase order/busy", int'(bad), 0);
        chk(!excl, "R5", "strobe exclusivity", int'(excl), 0);
        chk(seen, "R6", "done seen", int'(seen), 1);
        @(negedge clk);
        chk(cyc_done === 1'b0 && cyc_busy === 1'b0, "R7", "no restart after done",
            int'({cyc_done, cyc_busy}), 0);
        if (poked) sh[pidx] = pval;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R4 actual hung expected finished run");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        sh[0] = 8'h01; sh[1] = 8'h06; sh[2] = 8'h03;
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk({cyc_busy, addr_phase, cmd_strobe, rec_phase, cyc_done} === 5'b0,
            "R1", "outputs in reset", int'({cyc_busy, addr_phase, cmd_strobe, rec_phase, cyc_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk(8'h3A, 8'h01, "R1");
        read_chk(8'h3B, 8'h06, "R1");
        read_chk(8'h3C, 8'h03, "R1");
        // R2: unmapped index reads zero and writes do not alias.
        read_chk(8'h3D, 8'h00, "R2");
        write_reg(8'h3D, 8'hFF);
        write_reg(8'h39, 8'hFF);
        read_chk(8'h3D, 8'h00, "R2");
        read_chk(8'h3A, 8'h01, "R2");
        read_chk(8'h3B, 8'h06, "R2");
        read_chk(8'h3C, 8'h03, "R2");
        // R9: defaults give 2/7/4.
        chk(exp_len(sh[0]) == 2 && exp_len(sh[1]) == 7 && exp_len(sh[2]) == 4,
            "R9", "default lengths", exp_len(sh[1]), 7);
        do_cycle(1'b0);
        // Corner: zero multipliers give one-clock intervals (R3).
        write_reg(8'h3A, 8'h00); write_reg(8'h3B, 8'h00); write_reg(8'h3C, 8'h00);
        do_cycle(1'b0);
        // Corner: large prescaler codes (R3).
        write_reg(8'h3A, 8'h82); write_reg(8'h3B, 8'hC1); write_reg(8'h3C, 8'h45);
        read_chk(8'h3B, 8'hC1, "R2");
        do_cycle(1'b0);
        // Random registers, alternating mid-access pokes (R8, R7).
        for (int n = 0; n < 30; n++) begin
            for (int j = 0; j < 3; j++) begin
                if ($urandom % 2 == 0) write_reg(8'h3A + 8'(j), gen_reg());
            end
            read_chk(8'h3A + 8'(n % 3), sh[n % 3], "R2");
            do_cycle(n[0]);
        end
        summary();
    end
endmodule